// File: doc/BRIEF.md
# Key-Protected Configuration Register Bank

This block is the 32-bit configuration space of a DRAM controller. Software reaches it through a word-addressed bus: one write port with enable, address and data, and a separate combinational read port. Word 0 holds a lock word that a key scheme controls. The lock has three states. Open lets every write through. Soft lets only word 0 be written, so software can unlock again. Hard blocks every protected write, word 0 included, until the next reset.

A fixed set of interrupt and test words bypasses the lock completely. The configuration word at word 1 mixes bits that software writes with read-only fields: a hardware version, a fixed aperture code, and a RAM-size index worked out from the `RAM_SIZE_MIB` parameter. Two status words have bits forced on every write. When the lock drops a write, the block raises a pulse of one cycle on `wr_rejected`.

Top module: `cfg_guard_regs`

## Requirements
- R1: A write to word 0 stores 32'h0000_0001 (open) if the data is 32'hFC60_0309, 32'h0000_0010 (hard) if the data is 32'hDEAD_DEAD, and 32'h0000_0000 (soft) for any other data, as long as word 0 is writable.
- R2: While word 0 holds 32'h10, every write to a protected word is dropped, and that includes word 0. Only reset clears this state.
- R3: While word 0 holds 32'h0, writes to protected words other than word 0 are dropped, and word 0 still accepts new keys.
- R4: Word indices 20, 27, 29, 30, 31, 34, 35 and 45 (byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C, 0xB4) store any write verbatim in every lock state and never raise `wr_rejected`.
- R5: A write to word 1 stores (data & 32'h0FF0_3FB0) | (HW_VERSION << 28) | 32'hC | size index. The size index is 0, 1, 2 or 3 for 256, 512, 1024 or 2048 MiB. With the defaults (version 3, 512 MiB) the fixed part is 32'h3000_000D.
- R6: A write to word 24 (byte 0x60) stores the data with bit 0 cleared and bit 4 set.
- R7: A write to word 28 (byte 0x70) stores the data with bit 12 set and bit 13 cleared.
- R8: After reset every word is 0, except word 1, which holds its fixed fields (32'h3000_000D by default), and word 0, which holds 32'h0, or 32'h1 when `BOOT_OPEN` is 1.
- R9: A read at a word index below `NUM_WORDS` (64) returns the stored word, and a read above it returns 0. A write above it changes nothing and does not raise `wr_rejected`.
- R10: `wr_rejected` is high for exactly the one cycle after each write that the lock drops, and low at all other times.
- R11: While open, a write to any other protected in-range word stores the data verbatim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | ADDR_W (8) | Word index of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W (8) | Word index of the read |
| rd_data | output | 32 | Read data, combinational |
| wr_rejected | output | 1 | Pulse for a write that the lock dropped |

## Verification
The assertions assume that word 0 is only ever loaded through the key decode, and that every access is a full word with one write per cycle and no byte enables. They do not assume anything about which addresses or data values arrive. The stimulus drives `wr_en` for one cycle per access and moves every input on the falling edge. The random phase uses addresses up to 79, so writes above the bank are covered. The two keys appear often enough for the lock to change state many times. The hard key is held back until a dedicated phase, so the soft and open paths get enough traffic before the bank seals.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    localparam logic [31:0] KEY_OPEN  = 32'hFC60_0309;
    localparam logic [31:0] KEY_SEAL  = 32'hDEAD_DEAD;
    localparam logic [31:0] LOCK_SOFT = 32'h0000_0000;
    localparam logic [31:0] LOCK_OPEN = 32'h0000_0001;
    localparam logic [31:0] LOCK_HARD = 32'h0000_0010;

    localparam int unsigned IDX_LOCK = 0;
    localparam int unsigned IDX_CONF = 1;
    localparam int unsigned IDX_PHY  = 24;
    localparam int unsigned IDX_ECC  = 28;

    // read-only fields of the configuration word: 31:28, 19, 18:14, 6, 3:2, 1:0
    localparam logic [31:0] CONF_RO_MASK = 32'hF00F_C04F;

    typedef enum logic [1:0] {
        LK_SOFT = 2'd0,
        LK_OPEN = 2'd1,
        LK_HARD = 2'd2
    } lock_e;

    function automatic logic [1:0] size_index(input int mib);
        case (mib)
            256:     return 2'd0;
            512:     return 2'd1;
            1024:    return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic logic [31:0] conf_fixed(input int hw, input int mib);
        return (32'(hw & 15) << 28) | 32'h0000_000C | {30'd0, size_index(mib)};
    endfunction

    function automatic logic is_bypass(input logic [31:0] idx);
        case (idx)
            32'd20, 32'd27, 32'd29, 32'd30,
            32'd31, 32'd34, 32'd35, 32'd45: return 1'b1;
            default:                        return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cfgreg_key_decode.sv
module cfgreg_key_decode
    import cfgreg_pkg::*;
(
    input  logic [31:0] key_in,
    output logic [31:0] lock_code
);
    always_comb begin
        if (key_in == KEY_OPEN)      lock_code = LOCK_OPEN;
        else if (key_in == KEY_SEAL) lock_code = LOCK_HARD;
        else                         lock_code = LOCK_SOFT;
    end
endmodule

// File: rtl/cfgreg_access_filter.sv
module cfgreg_access_filter
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int NUM_WORDS = 64
) (
    input  logic              req,
    input  logic [ADDR_W-1:0] idx,
    input  logic [31:0]       lock_word,
    output logic              commit,
    output logic              drop
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_WORDS);

    lock_e lock_s;
    logic  in_range;
    logic  bypass;
    logic  is_lock;

    always_comb begin
        if (lock_word == LOCK_HARD)      lock_s = LK_HARD;
        else if (lock_word == LOCK_OPEN) lock_s = LK_OPEN;
        else                             lock_s = LK_SOFT;

        in_range = {1'b0, idx} < LIMIT;
        bypass   = is_bypass(32'(idx));
        is_lock  = 32'(idx) == IDX_LOCK;

        commit = 1'b0;
        drop   = 1'b0;
        if (req && in_range) begin
            if (bypass) begin
                commit = 1'b1;
            end else begin
                case (lock_s)
                    LK_OPEN: commit = 1'b1;
                    LK_SOFT: begin
                        commit = is_lock;
                        drop   = !is_lock;
                    end
                    default: drop = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgreg_field_merge.sv
module cfgreg_field_merge
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int HW_VERSION   = 3,
    parameter int RAM_SIZE_MIB = 512
) (
    input  logic [ADDR_W-1:0] idx,
    input  logic [31:0]       data_in,
    input  logic [31:0]       lock_code,
    output logic [31:0]       data_out
);
    localparam logic [31:0] FIXED = conf_fixed(HW_VERSION, RAM_SIZE_MIB);

    always_comb begin
        case (32'(idx))
            IDX_LOCK: data_out = lock_code;
            IDX_CONF: data_out = (data_in & ~CONF_RO_MASK) | FIXED;
            IDX_PHY:  data_out = (data_in & ~32'h0000_0001) | 32'h0000_0010;
            IDX_ECC:  data_out = (data_in | 32'h0000_1000) & ~32'h0000_2000;
            default:  data_out = data_in;
        endcase
    end
endmodule

// File: rtl/cfg_guard_regs.sv
module cfg_guard_regs
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int NUM_WORDS    = 64,
    parameter int HW_VERSION   = 3,
    parameter int RAM_SIZE_MIB = 512,
    parameter bit BOOT_OPEN    = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              wr_rejected
);
    localparam int              WIDX_W = $clog2(NUM_WORDS);
    localparam logic [ADDR_W:0] LIMIT  = (ADDR_W + 1)'(NUM_WORDS);

    typedef struct packed {
        logic [NUM_WORDS-1:0][31:0] words;
        logic                       rej;
    } bank_t;

    function automatic bank_t reset_image();
        bank_t r;
        r = '0;
        r.words[IDX_CONF] = conf_fixed(HW_VERSION, RAM_SIZE_MIB);
        r.words[IDX_LOCK] = BOOT_OPEN ? LOCK_OPEN : LOCK_SOFT;
        return r;
    endfunction

    localparam bank_t RESET_VAL = reset_image();

    bank_t st_d, st_q;

    logic [31:0] lock_word;
    logic [31:0] conf_word;
    logic [31:0] phy_word;
    logic [31:0] ecc_word;
    logic [31:0] key_code;
    logic [31:0] merged;
    logic        commit;
    logic        drop;

    assign lock_word = st_q.words[IDX_LOCK];
    assign conf_word = st_q.words[IDX_CONF];
    assign phy_word  = st_q.words[IDX_PHY];
    assign ecc_word  = st_q.words[IDX_ECC];

    cfgreg_key_decode u_key (
        .key_in   (wr_data),
        .lock_code(key_code)
    );

    cfgreg_access_filter #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS)
    ) u_filter (
        .req      (wr_en),
        .idx      (wr_addr),
        .lock_word(lock_word),
        .commit   (commit),
        .drop     (drop)
    );

    cfgreg_field_merge #(
        .ADDR_W      (ADDR_W),
        .HW_VERSION  (HW_VERSION),
        .RAM_SIZE_MIB(RAM_SIZE_MIB)
    ) u_merge (
        .idx      (wr_addr),
        .data_in  (wr_data),
        .lock_code(key_code),
        .data_out (merged)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rej = drop;
        if (commit) begin
            st_d.words[wr_addr[WIDX_W-1:0]] = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_VAL;
        else        st_q <= st_d;
    end

    assign rd_data     = ({1'b0, rd_addr} < LIMIT) ? st_q.words[rd_addr[WIDX_W-1:0]] : 32'h0;
    assign wr_rejected = st_q.rej;

endmodule

// File: rtl/cfg_guard_regs_checker.sv
module cfg_guard_regs_checker
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int NUM_WORDS    = 64,
    parameter int HW_VERSION   = 3,
    parameter int RAM_SIZE_MIB = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_rejected,
    input logic [31:0]       lock_word,
    input logic [31:0]       conf_word,
    input logic [31:0]       phy_word,
    input logic [31:0]       ecc_word
);
    logic in_rng;
    logic free_slot;
    assign in_rng = 32'(wr_addr) < 32'(NUM_WORDS);
    always_comb begin
        case (32'(wr_addr))
            32'd20, 32'd27, 32'd29, 32'd30, 32'd31, 32'd34, 32'd35, 32'd45: free_slot = 1'b1;
            default: free_slot = 1'b0;
        endcase
    end

    // R1: the lock word only ever holds one of its three codes
    a_r1_lock_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_word == 32'h0) || (lock_word == 32'h1) || (lock_word == 32'h10));

    a_r2_hard_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_word == 32'h10 |=> lock_word == 32'h10);

    a_r2_hard_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_rng && !free_slot && lock_word == 32'h10) |=> wr_rejected);

    a_r3_soft_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_rng && !free_slot && lock_word == 32'h0 && wr_addr != '0) |=> wr_rejected);

    a_r4_bypass_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && free_slot) |=> !wr_rejected);

    a_r5_conf_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (conf_word & 32'hF00F_C04F) == conf_fixed(HW_VERSION, RAM_SIZE_MIB));

    a_r6_phy_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_word[0]);

    a_r7_ecc_no_fail: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_word[13]);

    a_r9_oob_no_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !in_rng) |=> !wr_rejected);

    a_r10_reject_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rejected |-> $past(wr_en));
endmodule

bind cfg_guard_regs cfg_guard_regs_checker #(
    .ADDR_W      (ADDR_W),
    .NUM_WORDS   (NUM_WORDS),
    .HW_VERSION  (HW_VERSION),
    .RAM_SIZE_MIB(RAM_SIZE_MIB)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_rejected(wr_rejected),
    .lock_word  (lock_word),
    .conf_word  (conf_word),
    .phy_word   (phy_word),
    .ecc_word   (ecc_word)
);

// File: tb/cfg_guard_regs_tb_top.sv
`timescale 1ns/1ps
module cfg_guard_regs_tb_top;
    localparam int AW = 8;
    localparam int NW = 64;
    localparam logic [31:0] K_OPEN = 32'hFC60_0309;
    localparam logic [31:0] K_SEAL = 32'hDEAD_DEAD;
    localparam logic [31:0] CONF_RST = 32'h3000_000D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [31:0]   rd_data;
    logic          wr_rejected;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [31:0] m [NW];

    always #2.5 clk = ~clk;

    cfg_guard_regs #(.ADDR_W(AW), .NUM_WORDS(NW), .HW_VERSION(3),
                     .RAM_SIZE_MIB(512), .BOOT_OPEN(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_rejected(wr_rejected));

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
        end
    endtask

    function automatic bit free_slot(input int a);
        return a == 20 || a == 27 || a == 29 || a == 30 || a == 31 ||
               a == 34 || a == 35 || a == 45;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NW; i++) m[i] = 32'h0;
        m[1] = CONF_RST;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic do_write(input int a, input logic [31:0] d);
        string tag;
        bit rej;
        rej = 0;
        if (a >= NW) tag = "R9";
        else if (free_slot(a)) begin tag = "R4"; m[a] = d; end
        else if (m[0] == 32'h10) begin tag = "R2"; rej = 1; end
        else if (m[0] == 32'h0 && a != 0) begin tag = "R3"; rej = 1; end
        else if (a == 0) begin
            tag = "R1";
            m[0] = (d == K_OPEN) ? 32'h1 : (d == K_SEAL) ? 32'h10 : 32'h0;
        end else if (a == 1) begin
            tag = "R5";
            m[1] = (d & 32'h0FF0_3FB0) | CONF_RST;
        end else if (a == 24) begin
            tag = "R6";
            m[24] = (d & 32'hFFFF_FFFE) | 32'h10;
        end else if (a == 28) begin
            tag = "R7";
            m[28] = (d | 32'h1000) & 32'hFFFF_DFFF;
        end else begin tag = "R11"; m[a] = d; end

        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = AW'(a);
        wr_data = d;
        rd_addr = AW'(a);
        @(negedge clk);
        wr_en = 1'b0;
        check({tag, " R10 reject flag"}, {31'd0, wr_rejected}, {31'd0, rej});
        check({tag, " readback"}, rd_data, (a >= NW) ? 32'h0 : m[a]);
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < 80; a++) begin
            rd_addr = AW'(a);
            #0.1;
            check(tag, rd_data, (a >= NW) ? 32'h0 : m[a]);
        end
        check({tag, " reject idle"}, {31'd0, wr_rejected}, 32'h0);
    endtask

    function automatic int pick_addr();
        int sel;
        sel = $urandom_range(0, 15);
        case (sel)
            0, 1:    return 0;
            2:       return 1;
            3:       return 24;
            4:       return 28;
            5, 6:    begin
                int lst [8] = '{20, 27, 29, 30, 31, 34, 35, 45};
                return lst[$urandom_range(0, 7)];
            end
            default: return $urandom_range(0, 79);
        endcase
    endfunction

    function automatic logic [31:0] pick_data(input bit allow_seal);
        int sel;
        sel = $urandom_range(0, 15);
        if (sel < 4) return K_OPEN;
        if (sel == 4 && allow_seal) return K_SEAL;
        return $urandom();
    endfunction

    initial begin
        void'($urandom(32'd7411));
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_all("R8 reset image");

        // soft lock at reset: protected writes dropped, bypass words accepted
        do_write(5, 32'h1234_5678);
        do_write(1, 32'hFFFF_FFFF);
        do_write(20, 32'hA5A5_A5A5);
        do_write(45, 32'h0F0F_0F0F);
        do_write(70, 32'h1111_1111);
        // open, then exercise merges
        do_write(0, K_OPEN);
        do_write(1, 32'hFFFF_FFFF);
        do_write(1, 32'h0000_0000);
        do_write(24, 32'hFFFF_FFFF);
        do_write(24, 32'h0000_0000);
        do_write(28, 32'hFFFF_FFFF);
        do_write(28, 32'h0000_0000);
        do_write(5, 32'hCAFE_F00D);
        do_write(63, 32'hDEAD_BEEF);
        do_write(64, 32'h2222_2222);
        // relock with near-miss key
        do_write(0, K_OPEN ^ 32'h1);
        do_write(5, 32'h0);
        do_write(0, K_OPEN);
        do_write(0, 32'h0);

        for (int i = 0; i < 1500; i++) do_write(pick_addr(), pick_data(1'b0));

        // hard lock: sticky even against the open key
        do_write(0, K_OPEN);
        do_write(0, K_SEAL);
        do_write(0, K_OPEN);
        do_write(1, 32'h0FF0_3FB0);
        do_write(31, 32'h7777_7777);
        for (int i = 0; i < 500; i++) do_write(pick_addr(), pick_data(1'b1));
        read_all("R2 sealed bank");

        // reset is the only way out of hard lock
        do_reset();
        @(negedge clk);
        read_all("R8 R2 after reset");
        do_write(0, K_OPEN);
        for (int i = 0; i < 500; i++) do_write(pick_addr(), pick_data(1'b1));
        read_all("R9 final image");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule